// File: doc/BRIEF.md
# Receive Inactivity Timeout Detector

This block watches the receive side of a serial port and signals when characters are waiting in the receive FIFO but the line has gone quiet. It measures quiet time in character times. A character time is a fixed number of bit-period ticks, 10 by default for 8N1 framing. The tick comes from the baud generator. The block emits a single-cycle pulse that the interrupt logic uses to set its timeout status bit.

A 2-bit select field from the control register sets the length of the quiet period. Code 0 turns the detector off. Codes 1, 2 and 3 give 4, 8 and 16 character times with the default parameters.

The count runs only while the FIFO is not empty. It restarts on every received byte, on every host pop, and on every change of the select code. After it fires, the detector stays quiet until one of those restart conditions re-arms it.

Top module: `rx_idle_watch`

## Requirements
- R1: With `tmo_sel` = 1, 2 or 3 (bit 1 is the most significant bit), `tmo_pulse` rises for one cycle after the clock edge that samples the 40th, 80th or 160th `bit_tick` respectively. Ticks are counted from the last restart, and the count assumes no further restart. The character counts are BASE_CHARS times 1, 2 and 4.
- R2: With `tmo_sel` = 0, `tmo_pulse` never rises, however long data waits.
- R3: A cycle with `rx_byte` or `fifo_pop` high restarts the count from zero. A count cannot complete in a cycle that also carries such a pulse.
- R4: While `fifo_nonempty` is low, the count is held at zero and `tmo_pulse` stays low.
- R5: One character time is BITS_PER_CHAR (default 10) `bit_tick` pulses. Only cycles with `bit_tick` high advance the count, so gaps between ticks stretch the timeout in clock cycles but not in ticks.
- R6: The detector fires at most once per idle period. After a pulse it stays silent until a restart (byte, pop, empty FIFO or select change) occurs and a full new period elapses.
- R7: A change of `tmo_sel` between two cycles restarts the count under the new length.
- R8: While `rst_n` is low and on the first cycle after reset, `tmo_pulse` is low and the count is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per serial bit period |
| rx_byte | input | 1 | Pulse per byte written into the receive FIFO |
| fifo_pop | input | 1 | Pulse per host read of the receive FIFO |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one byte |
| tmo_sel | input | 2 | Timeout length code: 0 off, 1/2/3 short/medium/long |
| tmo_pulse | output | 1 | One-cycle pulse that sets the timeout status bit |

## Verification
The first pattern runs an uninterrupted quiet stretch with every code. It shows whether the pulse lands on exactly the right tick, and whether it is followed by silence. The second inserts a byte or a pop part way through a period, and the third drops the empty flag. These two separate the restart sources from plain counting. Sparse ticks (one every third cycle) and a mid-period code change show whether the count follows ticks rather than clocks, and whether it starts again under the new length. Code 0 is run over a period longer than the longest timeout. A bench model replays every cycle from tick arithmetic and compares the pulse on each one.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

   typedef enum logic [1:0] {
      TMO_OFF   = 2'd0,
      TMO_SHORT = 2'd1,
      TMO_MED   = 2'd2,
      TMO_LONG  = 2'd3
   } tmo_code_e;

   // Character-time multiplier for a code: 0, 1, 2, 4.
   function automatic int unsigned code_mult(input logic [1:0] code);
      case (code)
         TMO_SHORT: code_mult = 1;
         TMO_MED:   code_mult = 2;
         TMO_LONG:  code_mult = 4;
         default:   code_mult = 0;
      endcase
   endfunction

endpackage

// File: rtl/rx_idle_charclk.sv
// Turns bit-period ticks into character-time ticks; restart realigns phase.
module rx_idle_charclk #(
   parameter int unsigned BITS_PER_CHAR = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic restart,
   output logic char_tick
);
   generate
      if (BITS_PER_CHAR < 1) begin : g_bad
         $error("BITS_PER_CHAR must be at least 1");
      end else if (BITS_PER_CHAR == 1) begin : g_direct
         assign char_tick = bit_tick & ~restart;
      end else begin : g_div
         localparam int unsigned PW = $clog2(BITS_PER_CHAR);
         localparam logic [PW-1:0] LAST = PW'(BITS_PER_CHAR - 1);
         logic [PW-1:0] phase;

         assign char_tick = bit_tick & ~restart & (phase == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase <= '0;
            else if (restart)          phase <= '0;
            else if (bit_tick) begin
               if (phase == LAST)      phase <= '0;
               else                    phase <= phase + PW'(1);
            end
         end

         assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            phase <= LAST);
      end
   endgenerate
endmodule

// File: rtl/rx_idle_limit.sv
// Decodes the select code into a character-time limit.
module rx_idle_limit
   import rx_idle_pkg::*;
#(
   parameter int unsigned BASE_CHARS = 4,
   parameter int unsigned CW = $clog2(BASE_CHARS * 4 + 1)
) (
   input  logic [1:0]    code,
   output logic [CW-1:0] limit
);
   generate
      if (BASE_CHARS < 1) begin : g_bad
         $error("BASE_CHARS must be at least 1");
      end
      if ((BASE_CHARS * 4) >= (1 << CW)) begin : g_narrow
         $error("CW too narrow for the longest timeout");
      end
   endgenerate

   always_comb limit = CW'(BASE_CHARS * code_mult(code));
endmodule

// File: rtl/rx_idle_count.sv
// Counts character times; fires once when the limit is reached.
module rx_idle_count #(
   parameter int unsigned CW = 5,
   parameter int unsigned MAX_LIMIT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_tick,
   input  logic          restart,
   input  logic [CW-1:0] limit,
   output logic          fire
);
   logic [CW-1:0] cnt;
   logic          armed;
   logic [CW-1:0] cnt_nx;

   assign cnt_nx = cnt + CW'(1);
   assign fire   = char_tick & armed & ~restart & (cnt_nx == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (restart) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (char_tick && armed) begin
         if (cnt_nx == limit) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            cnt   <= cnt_nx;
         end
      end
   end

   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAX_LIMIT));
   assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed);
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch
   import rx_idle_pkg::*;
#(
   parameter int unsigned BITS_PER_CHAR = 10,
   parameter int unsigned BASE_CHARS    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic       rx_byte,
   input  logic       fifo_pop,
   input  logic       fifo_nonempty,
   input  logic [1:0] tmo_sel,
   output logic       tmo_pulse
);
   localparam int unsigned MAX_LIMIT = BASE_CHARS * 4;
   localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

   logic [1:0]    sel_q;
   logic          restart;
   logic          char_tick;
   logic          fire;
   logic [CW-1:0] limit;

   assign restart = rx_byte | fifo_pop | ~fifo_nonempty
                  | (tmo_sel == TMO_OFF) | (tmo_sel != sel_q);

   rx_idle_charclk #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_charclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .restart   (restart),
      .char_tick (char_tick)
   );

   rx_idle_limit #(.BASE_CHARS(BASE_CHARS), .CW(CW)) u_limit (
      .code  (tmo_sel),
      .limit (limit)
   );

   rx_idle_count #(.CW(CW), .MAX_LIMIT(MAX_LIMIT)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_tick (char_tick),
      .restart   (restart),
      .limit     (limit),
      .fire      (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 2'd0;
         tmo_pulse <= 1'b0;
      end else begin
         sel_q     <= tmo_sel;
         tmo_pulse <= fire;
      end
   end

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !tmo_pulse);
   assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> $past(tmo_sel) != 2'd0);
   assert_activity_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> !$past(rx_byte || fifo_pop));
   assert_empty_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> $past(fifo_nonempty));
   assert_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> $past(bit_tick));
endmodule

// File: tb/rx_idle_watch_bench.sv
module rx_idle_watch_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BPC  = 10;
   localparam int BASE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, rx_byte = 1'b0, fifo_pop = 1'b0, fifo_nonempty = 1'b0;
   logic [1:0] tmo_sel = 2'd0;
   logic tmo_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   int  ticks = 0;
   bit  fired = 1'b0;
   logic [1:0] psel = 2'd0;
   int  pulses = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_idle_watch #(.BITS_PER_CHAR(BPC), .BASE_CHARS(BASE)) u_rx_idle_watch (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_byte(rx_byte),
      .fifo_pop(fifo_pop), .fifo_nonempty(fifo_nonempty), .tmo_sel(tmo_sel),
      .tmo_pulse(tmo_pulse)
   );

   function automatic int lim_ticks(input logic [1:0] s);
      int m;
      m = (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : (s == 2'd3) ? 4 : 0;
      return m * BASE * BPC;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: tmo_pulse=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // One clock cycle: drive at negedge, compare right after the posedge.
   task automatic cyc(input logic bt, input logic rx, input logic pop,
                      input logic ne, input logic [1:0] sel, input string req);
      logic exp;
      @(negedge clk);
      bit_tick = bt; rx_byte = rx; fifo_pop = pop; fifo_nonempty = ne; tmo_sel = sel;
      if (rx || pop || !ne || sel == 2'd0 || sel != psel) begin
         ticks = 0; fired = 1'b0; exp = 1'b0;
      end else if (bt) begin
         ticks++;
         exp = (!fired && ticks == lim_ticks(sel));
         if (exp) fired = 1'b1;
      end else begin
         exp = 1'b0;
      end
      psel = sel;
      @(posedge clk);
      #1;
      if (tmo_pulse) pulses++;
      check(req, tmo_pulse, exp);
   endtask

   task automatic idle(input int n, input logic [1:0] sel, input string req);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, sel, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      check("R8", tmo_pulse, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R8", tmo_pulse, 1'b0);

      // R1 / R6: every code over a long quiet run, exact tick and a single pulse
      for (int s = 1; s < 4; s++) begin
         cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'(s), "R1");
         pulses = 0;
         idle(lim_ticks(2'(s)) + 60, 2'(s), "R1");
         checks++;
         if (pulses != 1) begin
            errors++;
            $display("FAIL R6: pulses=%0d expected=1 for code %0d", pulses, s);
         end
      end

      // R2: disabled code never fires
      pulses = 0;
      idle(250, 2'd0, "R2");
      checks++;
      if (pulses != 0) begin
         errors++;
         $display("FAIL R2: pulses=%0d expected=0", pulses);
      end

      // R3: byte and pop restart the count, including on the final tick
      idle(25, 2'd1, "R3");
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, "R3");
      idle(30, 2'd1, "R3");
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R3");
      idle(39, 2'd1, "R3");
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, "R3");   // would have been tick 40
      idle(45, 2'd1, "R3");

      // R4: empty FIFO holds the count
      for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, "R4");
      idle(45, 2'd1, "R4");

      // R5: sparse ticks stretch the period in clocks only
      for (int i = 0; i < 3 * 90; i++)
         cyc((i % 3) == 2, 1'b0, 1'b0, 1'b1, 2'd2, "R5");
      for (int i = 0; i < 50; i++)
         cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, "R5");

      // R7: select change restarts under the new length
      idle(100, 2'd3, "R7");
      idle(50, 2'd1, "R7");
      idle(30, 2'd3, "R7");
      idle(180, 2'd2, "R7");

      // R6: no repeat after firing, re-armed by a byte
      pulses = 0;
      idle(200, 2'd2, "R6");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, "R6");
      idle(90, 2'd2, "R6");
      checks++;
      if (pulses != 1) begin
         errors++;
         $display("FAIL R6: pulses=%0d expected=1 after re-arm", pulses);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule